// File: doc/BRIEF.md
# Circular Shift-Register Test Pattern Memory

This block is an on-chip store for the test vectors of a high-speed 6-bit DAC. A pattern is written in one bit at a time over a slow serial input, with every storage register chained into a single long path. Once the pattern is in place, the same registers are closed into rings. Each ring rotates by one position per slow clock, and the block presents eight 6-bit samples at once. A downstream serializer then interleaves those eight samples into the full-rate stream.

Storage consists of 48 rings, one for each bit of each lane, and each ring holds 104 bits. In every playback cycle every ring advances, whatever the stored values are, so the switching activity on the supply does not depend on the pattern. A pulse marks the first word of each 104-word period, so test equipment can align to the start of the pattern.

Top module: `circpat_mem`

## Requirements
- R1: While reset is low and in the first cycle after it, `word_out` and `period_wrap` are zero.
- R2: While `load_en` is high, the 48 rings form one 4992-bit chain that `ser_in` enters. The stream has to be sent ring 47 first and ring 0 last. Within each ring, bits go out in playback order. Stream bit j therefore becomes playback word j mod 104 of ring 47 − j/104.
- R3: Ring r carries bit r mod 6 of lane r/6, so lane L occupies `word_out[6L+5:6L]`, and lane 0 is the earliest sample. After a full load, the k-th run edge (counting from 0) puts word k onto `word_out`. The output is registered, so the word appears one cycle after `run_en` is sampled.
- R4: Playback is circular. Word k+104 equals word k for any number of periods, and the stored pattern is not lost.
- R5: When `load_en` and `run_en` are both high, loading takes place and `word_out` is zero.
- R6: During loading, `word_out` and `period_wrap` are zero.
- R7: When neither enable is high, `word_out` is zero, and both the contents and the playback position are kept. Playback then resumes with the next word.
- R8: `period_wrap` is high exactly alongside output words whose index mod 104 is 0. Any load cycle resets the index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial pattern bit, taken while loading |
| load_en | input | 1 | Shift the serial chain (has priority) |
| run_en | input | 1 | Rotate the rings and emit a word |
| word_out | output | 48 | Eight 6-bit samples, lane 0 in the low bits |
| period_wrap | output | 1 | High with the first word of each period |

## Verification
The bench uses four patterns. The first mixes lane and time index nonlinearly, so any swap of lanes, bits or word order shows up. The second is a linear ramp with a distinct lane offset, which exposes an off-by-one in the chain order. The third is an alternating checkerboard in lane and time, which catches a ring that fails to rotate. The fourth is all ones, which catches output gating that leaks zeros. Playback runs for more than two periods to show recirculation. A pause in mid-period shows that the position is held. A reload that overlaps `run_en`, started from the middle of a period, shows that load takes priority and that the period index restarts.

// File: rtl/circpat_pkg.sv
// Shared definitions for the circular pattern memory.
// Assumes: one operating mode per cycle, decoded from two enables.
package circpat_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_LOAD = 2'd1,
        MODE_RUN  = 2'd2
    } pb_mode_t;
endpackage

// File: rtl/circpat_row.sv
// One storage ring of DEPTH bits.
// In load mode it shifts in chain_in; in run mode it rotates its top bit
// back to bit 0; otherwise it holds.
// Assumes: mode is stable across each clock edge.
module circpat_row
    import circpat_pkg::*;
#(
    parameter int DEPTH = 104
) (
    input  logic     clk,
    input  logic     rst_n,
    input  pb_mode_t mode,
    input  logic     chain_in,
    output logic     tap,
    output logic     head
);
    logic [DEPTH-1:0] bits_q;

    // Shift, rotate or hold the ring contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            case (mode)
                MODE_LOAD: bits_q <= {bits_q[DEPTH-2:0], chain_in};
                MODE_RUN:  bits_q <= {bits_q[DEPTH-2:0], bits_q[DEPTH-1]};
                default:   bits_q <= bits_q;
            endcase
        end
    end

    assign tap  = bits_q[DEPTH-1];
    assign head = bits_q[0];
endmodule

// File: rtl/circpat_ctrl.sv
// Mode decoder and playback period counter.
// Load wins over run. The counter restarts on any load cycle, advances on
// run cycles, holds when idle, and wraps after DEPTH run cycles.
// Assumes: DEPTH >= 2.
module circpat_ctrl
    import circpat_pkg::*;
#(
    parameter int DEPTH = 104
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_en,
    input  logic     run_en,
    output pb_mode_t mode,
    output logic     first_word
);
    localparam int CW = $clog2(DEPTH);

    logic [CW-1:0] pos_q;

    // Decode the mode with load priority.
    always_comb begin
        if (load_en)     mode = MODE_LOAD;
        else if (run_en) mode = MODE_RUN;
        else             mode = MODE_IDLE;
    end

    // Track the playback word index within one period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (mode == MODE_LOAD) begin
            pos_q <= '0;
        end else if (mode == MODE_RUN) begin
            pos_q <= (pos_q == CW'(DEPTH-1)) ? '0 : pos_q + 1'b1;
        end
    end

    assign first_word = (mode == MODE_RUN) && (pos_q == '0);
endmodule

// File: rtl/circpat_mem.sv
// Top: LANES x SBITS rings of DEPTH bits.
// Ring r holds bit r%SBITS of lane r/SBITS. While loading, the rings form one
// chain from ring 0 upward. While running, every ring rotates and the tap bits
// are registered onto word_out; in any other mode the output is zero.
// Assumes: synchronous active-low reset.
module circpat_mem
    import circpat_pkg::*;
#(
    parameter int LANES = 8,
    parameter int SBITS = 6,
    parameter int DEPTH = 104
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_in,
    input  logic                   load_en,
    input  logic                   run_en,
    output logic [LANES*SBITS-1:0] word_out,
    output logic                   period_wrap
);
    localparam int NREG = LANES * SBITS;

    pb_mode_t        mode;
    logic            first_word;
    logic [NREG-1:0] row_tap;
    logic [NREG-1:0] row_head;
    logic [NREG-1:0] row_in;

    circpat_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .run_en     (run_en),
        .mode       (mode),
        .first_word (first_word)
    );

    // Chain input of each ring: the serial pin for ring 0, else the previous tap.
    assign row_in = {row_tap[NREG-2:0], ser_in};

    for (genvar r = 0; r < NREG; r++) begin : g_row
        circpat_row #(.DEPTH(DEPTH)) u_row (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (mode),
            .chain_in (row_in[r]),
            .tap      (row_tap[r]),
            .head     (row_head[r])
        );
    end

    // Register the output word and the period marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out    <= '0;
            period_wrap <= 1'b0;
        end else begin
            word_out    <= (mode == MODE_RUN) ? row_tap : '0;
            period_wrap <= first_word;
        end
    end
endmodule

// File: rtl/circpat_chk.sv
// Checker for circpat_mem: ring movement, output gating and period marking,
// tracked with its own period counter.
module circpat_chk #(
    parameter int NREG  = 48,
    parameter int DEPTH = 104
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ser_in,
    input logic            load_en,
    input logic            run_en,
    input logic [NREG-1:0] row_tap,
    input logic [NREG-1:0] row_head,
    input logic [NREG-1:0] word_out,
    input logic            period_wrap
);
    int unsigned ccnt;
    logic run_only;
    logic idle;

    assign run_only = run_en && !load_en;
    assign idle     = !run_en && !load_en;

    // Independent count of the period position.
    always_ff @(posedge clk) begin
        if (!rst_n || load_en)  ccnt <= 0;
        else if (run_en)        ccnt <= (ccnt == DEPTH-1) ? 0 : ccnt + 1;
    end

    a_r2_chain_entry: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> row_head[0] == $past(ser_in));

    for (genvar r = 1; r < NREG; r++) begin : g_chain
        a_r2_chain_link: assert property (@(posedge clk) disable iff (!rst_n)
            load_en |=> row_head[r] == $past(row_tap[r-1]));
    end

    for (genvar r = 0; r < NREG; r++) begin : g_ring
        a_r4_ring_rotate: assert property (@(posedge clk) disable iff (!rst_n)
            run_only |=> row_head[r] == $past(row_tap[r]));
    end

    a_r3_word_from_taps: assert property (@(posedge clk) disable iff (!rst_n)
        run_only |=> word_out == $past(row_tap));

    a_r5_load_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> word_out == '0);

    a_r6_load_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !period_wrap);

    a_r7_idle_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> (word_out == '0) && !period_wrap);

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> $stable(row_tap));

    a_r8_wrap_marks_start: assert property (@(posedge clk) disable iff (!rst_n)
        run_only |=> period_wrap == ($past(ccnt) == 0));
endmodule

bind circpat_mem circpat_chk #(.NREG(NREG), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_in      (ser_in),
    .load_en     (load_en),
    .run_en      (run_en),
    .row_tap     (row_tap),
    .row_head    (row_head),
    .word_out    (word_out),
    .period_wrap (period_wrap)
);

// File: tb/circpat_mem_tb.sv
`timescale 1ns/1ps
module circpat_mem_tb;
    localparam int LANES = 8;
    localparam int SBITS = 6;
    localparam int DEPTH = 104;
    localparam int NREG  = LANES * SBITS;
    localparam int TOTAL = NREG * DEPTH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0;
    logic load_en = 1'b0;
    logic run_en = 1'b0;
    logic [NREG-1:0] word_out;
    logic period_wrap;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int pos = 0;

    logic [NREG:0] exp_q[$];
    string         tag_q[$];

    always #2 clk = ~clk;

    circpat_mem #(.LANES(LANES), .SBITS(SBITS), .DEPTH(DEPTH)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_in      (ser_in),
        .load_en     (load_en),
        .run_en      (run_en),
        .word_out    (word_out),
        .period_wrap (period_wrap)
    );

    function automatic logic [5:0] sample(int seed, int l, int t);
        int v;
        case (seed)
            0:       v = (l * 7 + t * 3) ^ (t >> 2) ^ (l << 3);
            1:       v = t * 13 + l * 29 + 5;
            2:       v = ((l + t) % 2 == 1) ? 6'h15 : 6'h2A;
            default: v = 63;
        endcase
        return v[5:0];
    endfunction

    function automatic logic [NREG-1:0] word(int seed, int t);
        logic [NREG-1:0] w;
        for (int l = 0; l < LANES; l++) w[l*SBITS +: SBITS] = sample(seed, l, t);
        return w;
    endfunction

    // Driver: apply one cycle of inputs and queue the expected registered result.
    task automatic step(input logic ld, input logic rn, input logic d,
                        input logic [NREG-1:0] exp_w, input logic exp_wr, input string tag);
        @(negedge clk);
        load_en = ld;
        run_en  = rn;
        ser_in  = d;
        exp_q.push_back({exp_wr, exp_w});
        tag_q.push_back(tag);
    endtask

    // R2 stream order: ring 47 first; R5 when run overlaps the first cycles.
    task automatic load_pattern(input int seed, input int overlap);
        for (int j = 0; j < TOTAL; j++) begin
            int r;
            int t;
            logic [5:0] s;
            r = NREG - 1 - j / DEPTH;
            t = j % DEPTH;
            s = sample(seed, r / SBITS, t);
            step(1'b1, j < overlap, s[r % SBITS], '0, 1'b0, (j < overlap) ? "R5" : "R6");
        end
        pos = 0;
    endtask

    task automatic run_words(input int seed, input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 1'b1, 1'b0, word(seed, pos % DEPTH), (pos % DEPTH) == 0,
                 (pos < DEPTH) ? "R2 R3 R8" : "R4 R8");
            pos++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, 1'b0, "R7");
    endtask

    // Monitor: compare each result after the edge that produced it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [NREG:0] e;
                string tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                checks++;
                if ({period_wrap, word_out} !== e) begin
                    errors++;
                    $display("FAIL %s: got wrap=%0b word=%h expected wrap=%0b word=%h",
                             tg, period_wrap, word_out, e[NREG], e[NREG-1:0]);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;   // R1: reset values
        if (word_out !== '0 || period_wrap !== 1'b0) begin
            errors++;
            $display("FAIL R1: got wrap=%0b word=%h expected 0 and 0", period_wrap, word_out);
        end
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, '0, 1'b0, "R1");

        load_pattern(0, 0);
        run_words(0, 2 * DEPTH + 20);
        idle(5);
        run_words(0, 30);

        load_pattern(1, 12);
        run_words(1, DEPTH + 10);

        load_pattern(2, 0);
        run_words(2, 50);
        idle(3);
        run_words(2, 60);

        load_pattern(3, 0);
        run_words(3, 20);
        idle(2);

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule